// File: doc/BRIEF.md
# Tap-Selectable Ripple Timer Counter

This block is a long binary divider that runs in a system-clock domain. An external slow clock input is brought in through a two-flop synchronizer, and each of its falling edges advances a 24-stage binary count. One stage of that count drives a single registered timer output. A 4-bit select code picks the stage, and a skip control moves the selectable window to the low or to the high end of the chain. With the output fed by stage n, the timer output is a square wave at the input rate divided by 2^n, with an even duty cycle.

Four level controls shape the run. A clear forces everything to zero. A preset also zeroes the count but raises an output latch, so the output stays high until the first falling input edge after release; counting then begins on the second edge. Two hold inputs freeze the count while the input clock keeps running. When skip, clear and preset are all high, the chain splits into three 8-stage sections that count side by side, so a short burst of edges fills every stage. Two pass-through outputs carry the synchronised input clock.

Top module: `tap_ripple_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `tap_out`, `thru_a_out` and `thru_b_out` are 0 and the count is 0.
- R2: Stage n is count bit n-1. With `skip8_in` = 1 the code on `sel_in` drives stage code+1 (0 gives stage 1, 15 gives stage 16). With `skip8_in` = 0 it drives stage code+9 (0 gives stage 9, 15 gives stage 24). `tap_out` is registered and reflects a change of select one cycle later.
- R3: The count steps by one for each falling edge of `tick_in`. `tap_out` changes on the third rising `clk` edge after `tick_in` is first sampled low. Rising edges of `tick_in` never advance the count.
- R4: Outside the split mode, `clr_in` high zeroes the count and drives `tap_out` low on the next cycle. It wins over `set_in`.
- R5: `set_in` high, with `clr_in` low, zeroes the count and drives `tap_out` high. After `set_in` falls, the first falling input edge only drops `tap_out`, and the second edge is the first one counted.
- R6: While `hold_in` is high, falling input edges neither change the count nor clear the preset latch. Counting resumes on the first falling edge after it drops.
- R7: `osc_hold_in` has exactly the effect of `hold_in`.
- R8: With `skip8_in`, `set_in` and `clr_in` all high, the output latch is 0 and each 8-bit section (stages 1-8, 9-16 and 17-24) adds one on every unheld falling edge, so 255 edges leave every stage at 1.
- R9: When `set_in` and `clr_in` fall together, the chain counts again as one 24-bit binary value, and one falling edge takes an all-ones count to all zeros.
- R10: `thru_a_out` and `thru_b_out` both equal `tick_in` delayed by three `clk` cycles.
- R11: From reset, with stage n selected, `tap_out` first rises on falling edge 2^(n-1) and falls on edge 2^n. This gives a 2^n division with even duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | External clock to be divided (asynchronous) |
| set_in | input | 1 | Preset: clear count, force output high |
| clr_in | input | 1 | Clear: clear count, force output low |
| hold_in | input | 1 | Clock hold, freezes the count |
| osc_hold_in | input | 1 | Second hold input, same effect |
| skip8_in | input | 1 | Selects the low tap window instead of the high one |
| sel_in | input | 4 | Stage select code |
| tap_out | output | 1 | Registered timer output |
| thru_a_out | output | 1 | Synchronised copy of tick_in |
| thru_b_out | output | 1 | Second synchronised copy of tick_in |

## Verification
The bench measures where the output first rises and falls for every one of the 32 skip and code settings. This catches a tap window that is off by one stage or tied to the wrong end of the chain, because the output would then toggle after half or twice the expected number of edges. The stages too deep to reach by plain counting are filled through the split mode, then stepped through the all-ones to all-zeros wrap; a carry missing between sections would leave high stages set. The preset sequence is checked edge by edge, since a design that counted on the first edge after release would raise a stage-1 output one edge early. The hold inputs, clear-over-preset priority and the three-cycle input latency are checked against a cycle-accurate model on every clock.

// File: rtl/tap_timer_pkg.sv
package tap_timer_pkg;

  localparam int unsigned TT_STAGES = 24;
  localparam int unsigned TT_SEC_W  = 8;
  localparam int unsigned TT_SEL_W  = 4;
  localparam int unsigned TT_SYNC   = 2;

  // Per-cycle action of the stage chain
  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_CLEAR     = 3'd1,
    MODE_PRESET    = 3'd2,
    MODE_TEST_HOLD = 3'd3,
    MODE_TEST_STEP = 3'd4,
    MODE_UNLATCH   = 3'd5,
    MODE_STEP      = 3'd6
  } chain_mode_e;

  // Priority: split mode, clear, preset, hold / no edge, latch release, count
  function automatic chain_mode_e pick_mode(input logic split,
                                            input logic clr,
                                            input logic set,
                                            input logic inh,
                                            input logic fall,
                                            input logic latched);
    chain_mode_e m;
    if (split) begin
      m = (fall && !inh) ? MODE_TEST_STEP : MODE_TEST_HOLD;
    end else if (clr) begin
      m = MODE_CLEAR;
    end else if (set) begin
      m = MODE_PRESET;
    end else if (inh || !fall) begin
      m = MODE_IDLE;
    end else if (latched) begin
      m = MODE_UNLATCH;
    end else begin
      m = MODE_STEP;
    end
    return m;
  endfunction

endpackage

// File: rtl/tap_edge_sync.sv
module tap_edge_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fall
);

  logic [DEPTH:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[DEPTH-1:0], din};
    end
  end

  assign level = sh_q[DEPTH-1];
  assign fall  = sh_q[DEPTH] & ~sh_q[DEPTH-1];

  // R3: a single input fall is reported for exactly one cycle
  p_fall_single_r3: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/tap_stage_chain.sv
module tap_stage_chain
  import tap_timer_pkg::*;
#(
  parameter int unsigned STAGES = TT_STAGES,
  parameter int unsigned SEC_W  = TT_SEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  chain_mode_e       mode,
  output logic [STAGES-1:0] cnt_d,
  output logic              latch_d,
  output logic              latch_q
);

  localparam int unsigned NSEC = STAGES / SEC_W;

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] par_inc;
  logic [STAGES-1:0] ser_inc;

  // Split mode: each section is its own counter
  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign par_inc[s*SEC_W +: SEC_W] = cnt_q[s*SEC_W +: SEC_W] + 1'b1;
  end
  if (NSEC * SEC_W < STAGES) begin : g_rem
    assign par_inc[STAGES-1:NSEC*SEC_W] = cnt_q[STAGES-1:NSEC*SEC_W];
  end

  assign ser_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d   = cnt_q;
    latch_d = latch_q;
    case (mode)
      MODE_CLEAR: begin
        cnt_d   = '0;
        latch_d = 1'b0;
      end
      MODE_PRESET: begin
        cnt_d   = '0;
        latch_d = 1'b1;
      end
      MODE_TEST_HOLD: begin
        latch_d = 1'b0;
      end
      MODE_TEST_STEP: begin
        cnt_d   = par_inc;
        latch_d = 1'b0;
      end
      MODE_UNLATCH: begin
        latch_d = 1'b0;
      end
      MODE_STEP: begin
        cnt_d = ser_inc;
      end
      default: begin
        cnt_d   = cnt_q;
        latch_d = latch_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      latch_q <= latch_d;
    end
  end

  // R6 / R7: held or edge-free cycles leave the chain untouched
  p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_IDLE |=> $stable(cnt_q) && $stable(latch_q));

  // R5: the edge that releases the preset latch is not counted
  p_unlatch_nocount_r5: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_UNLATCH |=> $stable(cnt_q) && !latch_q);

  // R8: split mode never leaves the latch set
  p_split_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TEST_STEP || mode == MODE_TEST_HOLD) |=> !latch_q);

  // R3: a counted edge raises the value by exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_STEP |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/tap_stage_select.sv
module tap_stage_select #(
  parameter int unsigned STAGES = 24,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              skip_in,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [STAGES-1:0] cnt_d,
  input  logic              latch_d,
  output logic              tap_q
);

  localparam int unsigned TAPS = 2 ** SEL_W;
  localparam int unsigned SKIP = STAGES - TAPS;

  logic [TAPS-1:0] lo_win;
  logic            pick;

  assign lo_win = cnt_d[TAPS-1:0];

  if (SKIP > 0) begin : g_two_win
    logic [TAPS-1:0] hi_win;
    assign hi_win = cnt_d[STAGES-1:SKIP];
    assign pick   = skip_in ? lo_win[sel_in] : hi_win[sel_in];
  end else begin : g_one_win
    logic unused_skip;
    assign unused_skip = skip_in;
    assign pick        = lo_win[sel_in];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_q <= 1'b0;
    end else begin
      tap_q <= latch_d | pick;
    end
  end

endmodule

// File: rtl/tap_ripple_timer.sv
module tap_ripple_timer
  import tap_timer_pkg::*;
#(
  parameter int unsigned STAGES     = TT_STAGES,
  parameter int unsigned SEC_W      = TT_SEC_W,
  parameter int unsigned SEL_W      = TT_SEL_W,
  parameter int unsigned SYNC_DEPTH = TT_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             set_in,
  input  logic             clr_in,
  input  logic             hold_in,
  input  logic             osc_hold_in,
  input  logic             skip8_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tap_out,
  output logic             thru_a_out,
  output logic             thru_b_out
);

  logic              tick_lvl;
  logic              tick_fall;
  logic              split_w;
  logic              inh_w;
  logic              latch_q;
  logic              latch_d;
  logic [STAGES-1:0] cnt_d;
  chain_mode_e       mode;

  tap_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (tick_in),
    .level (tick_lvl),
    .fall  (tick_fall)
  );

  assign split_w = skip8_in & set_in & clr_in;
  assign inh_w   = hold_in | osc_hold_in;
  assign mode    = pick_mode(split_w, clr_in, set_in, inh_w, tick_fall, latch_q);

  tap_stage_chain #(.STAGES(STAGES), .SEC_W(SEC_W)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .cnt_d   (cnt_d),
    .latch_d (latch_d),
    .latch_q (latch_q)
  );

  tap_stage_select #(.STAGES(STAGES), .SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .skip_in (skip8_in),
    .sel_in  (sel_in),
    .cnt_d   (cnt_d),
    .latch_d (latch_d),
    .tap_q   (tap_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thru_a_out <= 1'b0;
      thru_b_out <= 1'b0;
    end else begin
      thru_a_out <= tick_lvl;
      thru_b_out <= tick_lvl;
    end
  end

  // R4: clear outside split mode pulls the output low
  p_clear_low_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_in && !split_w) |=> !tap_out);

  // R5: preset without clear drives the output high
  p_preset_high_r5: assert property (@(posedge clk) disable iff (rst)
    (set_in && !clr_in) |=> tap_out);

  // R10: both pass-through copies follow the synchronised input
  p_thru_follow_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(tick_lvl) |=> thru_a_out && thru_b_out);

endmodule

// File: tb/tb_tap_ripple_timer.sv
module tb_tap_ripple_timer;

  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       set_s = 1'b0;
  logic       clr_s = 1'b0;
  logic       hold = 1'b0;
  logic       osc_hold = 1'b0;
  logic       skip8 = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       tap, thru_a, thru_b;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    model_on = 1'b0;
  bit    finished = 1'b0;

  logic [23:0] m_cnt;
  bit          m_latch;
  bit          exp_tap;
  bit          exp_thru;
  bit          q[$];

  always #4 clk = ~clk;

  tap_ripple_timer dut (
    .clk         (clk),
    .rst         (rst),
    .tick_in     (tick),
    .set_in      (set_s),
    .clr_in      (clr_s),
    .hold_in     (hold),
    .osc_hold_in (osc_hold),
    .skip8_in    (skip8),
    .sel_in      (sel),
    .tap_out     (tap),
    .thru_a_out  (thru_a),
    .thru_b_out  (thru_b)
  );

  task automatic check_bit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: input history queue plus integer count
  always @(posedge clk) begin : model
    bit f;
    bit split;
    bit inh;
    int idx;
    if (rst) begin
      q = {};
      for (int i = 0; i <= SYNC; i++) q.push_back(1'b0);
      m_cnt = '0;
      m_latch = 1'b0;
      exp_tap = 1'b0;
      exp_thru = 1'b0;
      model_on = 1'b1;
    end else begin
      f = q[SYNC] && !q[SYNC-1];
      exp_thru = q[SYNC-1];
      split = skip8 && set_s && clr_s;
      inh = hold || osc_hold;
      if (split) begin
        m_latch = 1'b0;
        if (f && !inh) begin
          for (int s = 0; s < 3; s++) begin
            int v;
            v = (int'(m_cnt >> (8 * s)) & 255) + 1;
            m_cnt[8*s +: 8] = 8'(v % 256);
          end
        end
      end else if (clr_s) begin
        m_cnt = '0;
        m_latch = 1'b0;
      end else if (set_s) begin
        m_cnt = '0;
        m_latch = 1'b1;
      end else if (f && !inh) begin
        if (m_latch) m_latch = 1'b0;
        else m_cnt = m_cnt + 24'd1;
      end
      idx = skip8 ? int'(sel) : int'(sel) + 8;
      exp_tap = m_latch | m_cnt[idx];
      q.push_front(tick);
      void'(q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst && !finished) begin
      check_bit("tap vs model", tap, exp_tap);
      check_bit("thru_a vs model", thru_a, exp_thru);
      check_bit("thru_b vs model", thru_b, exp_thru);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fall_once();
    tick = 1'b1;
    wait_n(3);
    tick = 1'b0;
    wait_n(4);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    set_s = 1'b0; clr_s = 1'b0; hold = 1'b0; osc_hold = 1'b0; tick = 1'b0;
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // R11 / R2: divide ratio for one skip/code setting
  task automatic ratio(bit sk, int code);
    int n;
    int half;
    n = sk ? code + 1 : code + 9;
    skip8 = sk;
    sel = 4'(code);
    do_reset();
    if (n <= 10) begin
      cur_req = "R11 R2";
      half = 1 << (n - 1);
      for (int i = 1; i <= 2 * half; i++) begin
        fall_once();
        if (i == half - 1) check_bit("tap before first rise", tap, 1'b0);
        if (i == half)     check_bit("tap at first rise", tap, 1'b1);
        if (i == 2*half-1) check_bit("tap before fall", tap, 1'b1);
        if (i == 2*half)   check_bit("tap at fall", tap, 1'b0);
      end
    end else begin
      cur_req = "R9 R2";
      skip8 = 1'b1; set_s = 1'b1; clr_s = 1'b1;
      for (int i = 0; i < 255; i++) fall_once();
      skip8 = sk; set_s = 1'b0; clr_s = 1'b0;
      wait_n(2);
      check_bit("deep tap all ones", tap, 1'b1);
      fall_once();
      check_bit("deep tap after wrap", tap, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin : main
    // R1: reset state
    cur_req = "R1";
    rst = 1'b1;
    wait_n(3);
    check_bit("tap in reset", tap, 1'b0);
    check_bit("thru_a in reset", thru_a, 1'b0);
    check_bit("thru_b in reset", thru_b, 1'b0);
    rst = 1'b0;
    wait_n(1);
    check_bit("tap after reset", tap, 1'b0);

    // R3: latency and rising edges ignored
    cur_req = "R3";
    skip8 = 1'b1; sel = 4'd0;
    do_reset();
    tick = 1'b1;
    wait_n(6);
    check_bit("rising edge no count", tap, 1'b0);
    tick = 1'b0;
    wait_n(2);
    check_bit("tap two edges after fall", tap, 1'b0);
    wait_n(1);
    check_bit("tap three edges after fall", tap, 1'b1);
    wait_n(3);

    // R10: pass-through latency
    cur_req = "R10";
    tick = 1'b1;
    wait_n(5);
    check_bit("thru_a high", thru_a, 1'b1);
    check_bit("thru_b high", thru_b, 1'b1);
    tick = 1'b0;
    wait_n(2);
    check_bit("thru_a two cycles", thru_a, 1'b1);
    wait_n(1);
    check_bit("thru_a three cycles", thru_a, 1'b0);
    check_bit("thru_b three cycles", thru_b, 1'b0);
    wait_n(2);

    // R5: preset sequence
    cur_req = "R5";
    skip8 = 1'b1; sel = 4'd0;
    do_reset();
    repeat (3) fall_once();
    set_s = 1'b1;
    wait_n(3);
    check_bit("tap during preset", tap, 1'b1);
    set_s = 1'b0;
    wait_n(2);
    check_bit("tap after preset release", tap, 1'b1);
    fall_once();
    check_bit("first edge drops tap", tap, 1'b0);
    fall_once();
    check_bit("second edge counts", tap, 1'b1);
    sel = 4'd1;
    wait_n(2);
    check_bit("count is one", tap, 1'b0);

    // R4: clear and its priority over preset
    cur_req = "R4";
    sel = 4'd0;
    do_reset();
    fall_once();
    check_bit("counting before clear", tap, 1'b1);
    skip8 = 1'b0;
    clr_s = 1'b1;
    wait_n(2);
    check_bit("tap under clear", tap, 1'b0);
    set_s = 1'b1;
    wait_n(2);
    check_bit("clear beats preset", tap, 1'b0);
    set_s = 1'b0; clr_s = 1'b0; skip8 = 1'b1;
    wait_n(2);
    check_bit("count cleared", tap, 1'b0);

    // R6: clock hold
    cur_req = "R6";
    do_reset();
    fall_once();
    hold = 1'b1;
    repeat (3) fall_once();
    check_bit("held count", tap, 1'b1);
    hold = 1'b0;
    fall_once();
    check_bit("resume after hold", tap, 1'b0);

    // R7: second hold input
    cur_req = "R7";
    sel = 4'd1;
    do_reset();
    repeat (2) fall_once();
    check_bit("count two", tap, 1'b1);
    osc_hold = 1'b1;
    repeat (2) fall_once();
    check_bit("osc hold keeps count", tap, 1'b1);
    osc_hold = 1'b0;
    repeat (2) fall_once();
    check_bit("resume after osc hold", tap, 1'b0);

    // R8 / R9: split mode fill and wrap
    cur_req = "R8";
    sel = 4'd0; skip8 = 1'b1;
    do_reset();
    set_s = 1'b1; clr_s = 1'b1;
    wait_n(2);
    check_bit("split mode latch low", tap, 1'b0);
    repeat (5) fall_once();
    check_bit("section0 bit0", tap, 1'b1);
    sel = 4'd8;
    wait_n(2);
    check_bit("section1 bit0", tap, 1'b1);
    sel = 4'd9;
    wait_n(2);
    check_bit("section1 bit1", tap, 1'b0);
    repeat (250) fall_once();
    sel = 4'd15;
    wait_n(2);
    check_bit("section1 full", tap, 1'b1);
    cur_req = "R9";
    set_s = 1'b0; clr_s = 1'b0;
    wait_n(2);
    check_bit("series all ones", tap, 1'b1);
    skip8 = 1'b0;
    wait_n(2);
    check_bit("stage24 set", tap, 1'b1);
    fall_once();
    check_bit("stage24 after wrap", tap, 1'b0);
    skip8 = 1'b1; sel = 4'd0;
    wait_n(2);
    check_bit("stage1 after wrap", tap, 1'b0);

    // R11 / R2: all 32 tap settings
    for (int sk = 1; sk >= 0; sk--) begin
      for (int code = 0; code < 16; code++) begin
        ratio(sk[0], code);
      end
    end

    wait_n(4);
    finish_run();
  end

endmodule